// File: doc/BRIEF.md
# Hex Record Stream Stripper

This block sits between a byte source that delivers the ASCII text of a hex-record configuration image and a flash programming engine that wants raw data bytes. Characters arrive one per cycle on a valid/ready handshake. Data bytes leave on a second valid/ready handshake. Between the two, the block discards whole metadata records and the framing characters on each line, then packs the remaining hex digits into bytes.

Records are recognised by where they sit in the file, not by their contents. Counting only non-empty lines and starting from zero, every line whose position is a multiple of `LINE_PERIOD` is a metadata record, and that includes the first line. The final non-empty line, marked by `chr_last_i` on the last character of the file, is also a metadata record. On every other line, the first `HEAD` characters (start code, length, address, type) and the last `TAIL` characters (checksum) are trimmed. The final line can only be identified once the file ends, so the block holds each kept line's bytes in an internal buffer. It releases them only when the next non-empty line begins.

An invalid digit, an odd digit count or an over-long line sets a sticky error flag, which is cleared only by reset. After the character flagged with `chr_last_i`, line counting starts again from zero, so several files can be streamed back to back.

Top module: `hex_rec_stripper`

## Requirements
- R1: After reset, `byte_valid_o` is 0, `err_o` is 0 and `chr_ready_o` is 1.
- R2: The non-empty line at position 0 of a file produces no output bytes.
- R3: Every non-empty line whose position (0-based, empty lines not counted) is a multiple of `LINE_PERIOD` produces no output bytes.
- R4: The last non-empty line of a file produces no output bytes. This holds whether the character carrying `chr_last_i` is the line's own final character or a line ending placed after it.
- R5: On every other line, the first `HEAD` and the last `TAIL` non-line-ending characters are discarded. Only the characters between them are decoded.
- R6: Decoded characters form bytes in pairs, the first character giving bits 7:4 and the second bits 3:0. Digits 0-9, A-F and a-f are accepted.
- R7: CR (0x0D) and LF (0x0A) each end a line. A CR LF pair counts as one line end, and lines with no other characters are ignored entirely.
- R8: Bytes of a kept line do not appear on the output until the first character of the next non-empty line has been accepted.
- R9: A character in the decoded window that is not a hex digit is skipped and sets `err_o`. `err_o` then stays 1 until reset.
- R10: A kept line with an odd number of decoded digits sets `err_o`. Its full bytes are emitted and its trailing digit is dropped.
- R11: A kept line with more than `MAX_BYTES` bytes sets `err_o`. Only its first `MAX_BYTES` bytes are emitted.
- R12: While `byte_valid_o` is 1 and `byte_ready_i` is 0, the output byte holds steady. When the internal buffer is full, `chr_ready_o` drops and no character or byte is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chr_valid_i | input | 1 | Input character valid |
| chr_data_i | input | 8 | ASCII character |
| chr_last_i | input | 1 | Marks the final character of the file |
| chr_ready_o | output | 1 | Character accepted when high with valid |
| byte_valid_o | output | 1 | Output byte valid |
| byte_data_o | output | 8 | Decoded data byte |
| byte_ready_i | input | 1 | Downstream accepts byte |
| err_o | output | 1 | Sticky format error |

## Verification
The bench builds the block with `LINE_PERIOD` = 5 and `MAX_BYTES` = 8, keeping `HEAD` = 9 and `TAIL` = 2. A period of five puts one or two periodic metadata drops inside files of only nine to eleven lines. The eight-byte line limit makes the line-length overflow cheap to reach. It also shrinks the buffer to sixteen bytes, so a mostly-stalled consumer quickly drives `chr_ready_o` low. Files mix CR LF, bare LF and bare CR endings, include blank lines, and end both with and without a final line ending. This covers both ways the last record is withdrawn: while it is still being received, and after it has already been parked.

// File: rtl/hxs_pkg.sv
package hxs_pkg;

  localparam logic [7:0] CH_CR = 8'h0D;
  localparam logic [7:0] CH_LF = 8'h0A;

  typedef struct packed {
    logic       ok;
    logic [3:0] nib;
  } hex_nib_t;

  function automatic hex_nib_t hex_decode(input logic [7:0] c);
    hex_nib_t r;
    r.ok  = 1'b1;
    r.nib = '0;
    if (c >= 8'h30 && c <= 8'h39)      r.nib = 4'(c - 8'h30);
    else if (c >= 8'h41 && c <= 8'h46) r.nib = 4'(c - 8'h37);
    else if (c >= 8'h61 && c <= 8'h66) r.nib = 4'(c - 8'h57);
    else                               r.ok  = 1'b0;
    return r;
  endfunction

  function automatic logic is_line_end(input logic [7:0] c);
    return (c == CH_CR) || (c == CH_LF);
  endfunction

endpackage

// File: rtl/hxs_line_ctl.sv
// Per-line character position, line position and checksum-trim delay.
module hxs_line_ctl import hxs_pkg::*; #(
  parameter int HEAD        = 9,
  parameter int TAIL        = 2,
  parameter int LINE_PERIOD = 4097
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       acc_i,
  input  logic [7:0] chr_i,
  input  logic       last_i,
  output logic       first_o,
  output logic       line_end_o,
  output logic       drop_o,
  output logic       busy_o,
  output logic       dig_v_o,
  output logic [7:0] dig_o
);

  localparam int IDX_W = $clog2(HEAD + 2);
  localparam int POS_W = $clog2(LINE_PERIOD + 1);
  localparam int CNT_W = $clog2(TAIL + 1);

  logic             active_q;
  logic [IDX_W-1:0] idx_q;
  logic [POS_W-1:0] pos_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       dly_q [TAIL];
  logic             eol, in_win;

  assign eol        = is_line_end(chr_i);
  assign in_win     = (idx_q >= IDX_W'(HEAD));
  assign first_o    = acc_i && !eol && !active_q;
  assign line_end_o = acc_i && eol && active_q;
  assign drop_o     = (pos_q == '0);
  assign busy_o     = active_q || (acc_i && !eol);
  // a digit leaves the delay only once TAIL newer characters are behind it
  assign dig_v_o    = acc_i && !eol && in_win && (cnt_q == CNT_W'(TAIL)) && !drop_o;
  assign dig_o      = dly_q[TAIL-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      pos_q    <= '0;
      cnt_q    <= '0;
      for (int k = 0; k < TAIL; k++) dly_q[k] <= '0;
    end else if (acc_i) begin
      if (last_i || eol) begin
        active_q <= 1'b0;
        idx_q    <= '0;
        cnt_q    <= '0;
        if (last_i)
          pos_q <= '0;
        else if (active_q)
          pos_q <= (pos_q == POS_W'(LINE_PERIOD - 1)) ? '0 : pos_q + POS_W'(1);
      end else begin
        active_q <= 1'b1;
        if (!in_win) begin
          idx_q <= idx_q + IDX_W'(1);
        end else begin
          dly_q[0] <= chr_i;
          for (int k = 1; k < TAIL; k++) dly_q[k] <= dly_q[k-1];
          if (cnt_q != CNT_W'(TAIL)) cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/hxs_nib_pack.sv
// Pairs hex digits into bytes, high nibble first.
module hxs_nib_pack import hxs_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       dig_v_i,
  input  logic [7:0] dig_i,
  input  logic       clr_i,
  output logic       bad_o,
  output logic       half_o,
  output logic       byte_v_o,
  output logic [7:0] byte_o
);

  hex_nib_t   h;
  logic       half_q;
  logic [3:0] hi_q;

  assign h        = hex_decode(dig_i);
  assign bad_o    = dig_v_i && !h.ok;
  assign byte_v_o = dig_v_i && h.ok && half_q;
  assign byte_o   = {hi_q, h.nib};
  assign half_o   = half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= 1'b0;
      hi_q   <= '0;
    end else if (clr_i) begin
      half_q <= 1'b0;
    end else if (dig_v_i && h.ok) begin
      if (half_q) begin
        half_q <= 1'b0;
      end else begin
        hi_q   <= h.nib;
        half_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/hxs_byte_fifo.sv
// Byte FIFO with a release pointer (read side stops there) and write rewind.
module hxs_byte_fifo #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [7:0]    wr_data_i,
  input  logic          rew_en_i,
  input  logic [PW-1:0] rew_ptr_i,
  input  logic          rel_en_i,
  input  logic [PW-1:0] rel_ptr_i,
  output logic [PW-1:0] wr_ptr_o,
  output logic [PW-1:0] used_o,
  output logic          rd_valid_o,
  output logic [7:0]    rd_data_o,
  input  logic          rd_ready_i
);

  logic [7:0]    mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q, lim_q;

  assign wr_ptr_o   = wr_q;
  assign used_o     = wr_q - rd_q;
  assign rd_valid_o = (rd_q != lim_q);
  assign rd_data_o  = mem_q[rd_q[AW-1:0]];

  always_ff @(posedge clk_i) begin
    if (wr_en_i && !rew_en_i) mem_q[wr_q[AW-1:0]] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lim_q <= '0;
    end else begin
      if (rew_en_i)     wr_q <= rew_ptr_i;
      else if (wr_en_i) wr_q <= wr_q + PW'(1);
      if (rel_en_i)     lim_q <= rel_ptr_i;
      if (rd_valid_o && rd_ready_i) rd_q <= rd_q + PW'(1);
    end
  end

endmodule

// File: rtl/hex_rec_stripper.sv
module hex_rec_stripper import hxs_pkg::*; #(
  parameter int HEAD        = 9,
  parameter int TAIL        = 2,
  parameter int LINE_PERIOD = 4097,
  parameter int MAX_BYTES   = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       chr_valid_i,
  input  logic [7:0] chr_data_i,
  input  logic       chr_last_i,
  output logic       chr_ready_o,
  output logic       byte_valid_o,
  output logic [7:0] byte_data_o,
  input  logic       byte_ready_i,
  output logic       err_o
);

  localparam int DEPTH = 2 * MAX_BYTES;
  localparam int PW    = $clog2(DEPTH) + 1;

  logic          acc, last_acc, first, line_end, drop, busy, dig_v;
  logic [7:0]    dig, pk_byte;
  logic          bad, half, pk_v, odd, ovf, room, wr_en, rew_en, rel_en;
  logic [PW-1:0] used, wr_ptr, rew_ptr, line_bytes;
  logic [PW-1:0] cur_start_q, pend_start_q;
  logic          pend_valid_q, err_q;

  assign chr_ready_o = (used < PW'(DEPTH));
  assign acc         = chr_valid_i && chr_ready_o;
  assign last_acc    = acc && chr_last_i;

  hxs_line_ctl #(
    .HEAD        (HEAD),
    .TAIL        (TAIL),
    .LINE_PERIOD (LINE_PERIOD)
  ) i_line_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (acc),
    .chr_i      (chr_data_i),
    .last_i     (chr_last_i),
    .first_o    (first),
    .line_end_o (line_end),
    .drop_o     (drop),
    .busy_o     (busy),
    .dig_v_o    (dig_v),
    .dig_o      (dig)
  );

  hxs_nib_pack i_nib_pack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dig_v_i  (dig_v),
    .dig_i    (dig),
    .clr_i    (line_end || last_acc),
    .bad_o    (bad),
    .half_o   (half),
    .byte_v_o (pk_v),
    .byte_o   (pk_byte)
  );

  assign line_bytes = wr_ptr - cur_start_q;
  assign room       = (line_bytes < PW'(MAX_BYTES));
  assign wr_en      = pk_v && room;
  assign ovf        = pk_v && !room;
  assign odd        = line_end && !chr_last_i && half;
  // end of file: withdraw the line in progress, else the parked one
  assign rew_en     = last_acc && (busy || pend_valid_q);
  assign rew_ptr    = busy ? cur_start_q : pend_start_q;
  // a new non-empty line proves the parked line is not the last
  assign rel_en     = first && pend_valid_q;

  hxs_byte_fifo #(.DEPTH(DEPTH)) i_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_data_i  (pk_byte),
    .rew_en_i   (rew_en),
    .rew_ptr_i  (rew_ptr),
    .rel_en_i   (rel_en),
    .rel_ptr_i  (cur_start_q),
    .wr_ptr_o   (wr_ptr),
    .used_o     (used),
    .rd_valid_o (byte_valid_o),
    .rd_data_o  (byte_data_o),
    .rd_ready_i (byte_ready_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_start_q  <= '0;
      pend_start_q <= '0;
      pend_valid_q <= 1'b0;
      err_q        <= 1'b0;
    end else begin
      if (bad || odd || ovf) err_q <= 1'b1;
      if (last_acc) begin
        pend_valid_q <= 1'b0;
        cur_start_q  <= rew_en ? rew_ptr : wr_ptr;
      end else if (line_end) begin
        if (!drop) begin
          pend_start_q <= cur_start_q;
          pend_valid_q <= 1'b1;
        end
        cur_start_q <= wr_ptr;
      end else if (rel_en) begin
        pend_valid_q <= 1'b0;
      end
    end
  end

  assign err_o = err_q;

endmodule

// File: rtl/hxs_chk.sv
module hxs_chk #(
  parameter int MAX_BYTES = 32,
  localparam int DEPTH = 2 * MAX_BYTES,
  localparam int PW    = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ready_i,
  input logic          ovalid_i,
  input logic          oready_i,
  input logic [7:0]    odata_i,
  input logic          err_i,
  input logic [PW-1:0] used_i
);

  // R12
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovalid_i && !oready_i |=> ovalid_i && $stable(odata_i));

  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> err_i);

  // R12
  no_write_stalled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |=> used_i <= $past(used_i));

  // R8
  valid_has_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovalid_i |-> used_i != '0);

  // R12
  used_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used_i <= PW'(DEPTH));

endmodule

bind hex_rec_stripper hxs_chk #(.MAX_BYTES(MAX_BYTES)) i_hxs_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ready_i  (chr_ready_o),
  .ovalid_i (byte_valid_o),
  .oready_i (byte_ready_i),
  .odata_i  (byte_data_o),
  .err_i    (err_o),
  .used_i   (used)
);

// File: tb/test_hex_rec_stripper.sv
`timescale 1ns/1ps
module test_hex_rec_stripper;

  localparam int HEAD = 9;
  localparam int TAIL = 2;
  localparam int PER  = 5;
  localparam int MAXB = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chr_valid = 1'b0;
  logic [7:0] chr_data = '0;
  logic       chr_last = 1'b0;
  logic       chr_ready;
  logic       byte_valid;
  logic [7:0] byte_data;
  logic       byte_ready = 1'b0;
  logic       err;

  always #2.5 clk = ~clk;

  hex_rec_stripper #(
    .HEAD(HEAD), .TAIL(TAIL), .LINE_PERIOD(PER), .MAX_BYTES(MAXB)
  ) i_hex_rec_stripper (
    .clk_i(clk), .rst_ni(rst_n),
    .chr_valid_i(chr_valid), .chr_data_i(chr_data), .chr_last_i(chr_last),
    .chr_ready_o(chr_ready),
    .byte_valid_o(byte_valid), .byte_data_o(byte_data), .byte_ready_i(byte_ready),
    .err_o(err)
  );

  logic [7:0]  exp_q[$];
  string       tag_q[$];
  int          n_cmp = 0, n_bad = 0, n_rx = 0, n_stall = 0, bp_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic        rdy_n;
  logic [7:0]  e_b;
  string       e_t;
  bit          done = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (bp_mode)
      0:       rdy_n = 1'b1;
      1:       rdy_n = lfsr[0] | lfsr[1];
      default: rdy_n = (lfsr[3:0] == 4'h0);
    endcase
    if (!rst_n) rdy_n = 1'b0;
    byte_ready = rdy_n;
    if (rdy_n && byte_valid) begin
      n_rx++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4", "unexpected byte", int'(byte_data), 0);
      end else begin
        e_b = exp_q.pop_front();
        e_t = tag_q.pop_front();
        chk(byte_data == e_b, e_t, "data byte", int'(byte_data), int'(e_b));
      end
    end
  end

  task automatic send_chr(input logic [7:0] c, input bit last);
    @(negedge clk);
    chr_valid = 1'b1; chr_data = c; chr_last = last;
    while (!chr_ready) begin
      n_stall++;
      @(negedge clk);
    end
    @(posedge clk);
    #1 chr_valid = 1'b0; chr_last = 1'b0;
  endtask

  // kind 0: CR LF, 1: LF, 2: CR
  task automatic send_eol(input int kind, input bit last);
    if (kind == 0) begin send_chr(8'h0D, 1'b0); send_chr(8'h0A, last); end
    else if (kind == 1) send_chr(8'h0A, last);
    else send_chr(8'h0D, last);
  endtask

  task automatic send_line(input string s, input bit last);
    for (int k = 0; k < s.len(); k++) send_chr(s[k], 1'b0);
    send_eol(0, last);
  endtask

  function automatic string make_rec(input logic [7:0] d[$], input int i);
    logic [7:0]  sum;
    logic [15:0] addr;
    string       s;
    addr = 16'(i * 16);
    sum  = 8'(d.size()) + addr[15:8] + addr[7:0];
    s = $sformatf(":%02X%04X00", d.size(), addr);
    foreach (d[k]) begin
      s = {s, (i % 2) ? $sformatf("%02x", d[k]) : $sformatf("%02X", d[k])};
      sum = sum + d[k];
    end
    s = {s, $sformatf("%02X", 8'(~sum + 8'h01))};
    return s;
  endfunction

  task automatic drain();
    for (int k = 0; k < 3000 && exp_q.size() != 0; k++) @(negedge clk);
    repeat (30) @(negedge clk);
  endtask

  task automatic run_file(input int nl, input int kind, input bit trail, input bit blanks,
                          input bit hold, input string req);
    int         rx0, exp_n, l1n, nb;
    bit         is_last, kept;
    logic [7:0] d[$];
    string      s;
    rx0 = n_rx; exp_n = 0; l1n = 0;
    for (int i = 0; i < nl; i++) begin
      nb = 1 + int'($urandom_range(MAXB - 1));
      d.delete();
      for (int k = 0; k < nb; k++) d.push_back(8'($urandom));
      s = make_rec(d, i);
      is_last = (i == nl - 1);
      kept = ((i % PER) != 0) && !is_last;  // R2 R3 R4
      if (kept) begin
        foreach (d[k]) begin
          exp_q.push_back(d[k]);
          tag_q.push_back((i % 2) ? "R6" : "R5");
        end
        exp_n += nb;
      end
      if (i == 1) l1n = kept ? nb : 0;
      for (int k = 0; k < s.len(); k++) begin
        send_chr(s[k], is_last && !trail && (k == s.len() - 1));
        if (hold && i == 2 && k == 0) begin
          repeat (40) @(negedge clk);
          chk(n_rx - rx0 == l1n, "R8", "released at next line", n_rx - rx0, l1n);
        end
      end
      if (!is_last || trail) send_eol(kind, is_last);
      if (hold && i == 1) begin
        repeat (40) @(negedge clk);
        chk(n_rx == rx0, "R8", "held while unconfirmed", n_rx - rx0, 0);
      end
      if (blanks && !is_last) send_eol(kind, 1'b0);  // R7 empty line
    end
    drain();
    chk(n_rx - rx0 == exp_n, req, "byte count", n_rx - rx0, exp_n);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic err_case(input string bad_line, input string req);
    do_reset();
    chk(err == 1'b0, "R1", "error clear after reset", int'(err), 0);
    send_line(":020000040000FA", 1'b0);
    send_line(bad_line, 1'b0);
    repeat (4) @(negedge clk);
    chk(err == 1'b1, req, "error raised", int'(err), 1);
    exp_q.push_back(8'h55); tag_q.push_back("R5");
    send_line(":0100000055AA", 1'b0);
    send_line(":00000001FF", 1'b1);
    drain();
    chk(err == 1'b1, "R9", "error sticky", int'(err), 1);
  endtask

  initial begin
    do_reset();
    chk(byte_valid == 1'b0, "R1", "valid after reset", int'(byte_valid), 0);
    chk(err == 1'b0, "R1", "error after reset", int'(err), 0);
    chk(chr_ready == 1'b1, "R1", "ready after reset", int'(chr_ready), 1);

    bp_mode = 1;
    run_file(9, 0, 1'b1, 1'b0, 1'b1, "R3");   // CR LF, two periodic drops
    chk(err == 1'b0, "R5", "no error on clean file", int'(err), 0);
    run_file(8, 1, 1'b0, 1'b1, 1'b0, "R7");   // LF, blank lines, no final newline
    run_file(7, 2, 1'b1, 1'b0, 1'b0, "R4");   // bare CR, final newline
    run_file(2, 0, 1'b1, 1'b0, 1'b0, "R2");   // only first and last records
    run_file(3, 1, 1'b0, 1'b0, 1'b0, "R4");

    bp_mode = 2; n_stall = 0;
    run_file(11, 0, 1'b1, 1'b0, 1'b0, "R12");
    chk(n_stall > 0, "R12", "input stalled on full buffer", n_stall, 1);
    bp_mode = 1;

    exp_q.push_back(8'h12); tag_q.push_back("R9");
    err_case(":030000001G2FF", "R9");
    exp_q.push_back(8'hAB); tag_q.push_back("R10");
    err_case(":02000000ABCFF", "R10");
    for (int k = 1; k <= 8; k++) begin
      exp_q.push_back(8'(k * 17)); tag_q.push_back("R11");
    end
    err_case(":0900000011223344556677889900", "R11");

    chk(exp_q.size() == 0, "R4", "scoreboard empty", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule